// File: doc/BRIEF.md
# Four-Channel DMA Request Pacer

This block sits at the front of a DMA controller and decides when each of four channels asks the transfer engine for one single transfer. Each channel has a peripheral request line, a 2-bit operating mode, a pacing interval in clock cycles and a transfer count. A channel is armed by a start pulse, which loads its count. When mode bit 1 is set, a rising request edge produces one transfer at once. It also starts a per-channel down-counting pacer. That pacer asks for one more transfer every interval for as long as the request stays high.

Every channel keeps a pending flag. A small arbiter state machine has two states. In `ARB_IDLE` it waits for any pending channel. On the transition *grant* it picks the lowest-numbered pending channel and enters `ARB_ISSUE`. There it holds a valid/ready handshake to the transfer engine. On the transition *accept*, when ready is seen, the channel's count drops by one and the arbiter returns to `ARB_IDLE`. When a count reaches zero, the channel stops its pacer and drops its active bit. It also sets three completion bits in its status byte. Software clears those bits by writing ones.

Top module: `dma_req_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it, `xfer_valid_o` is 0 and every status byte reads 0x00.
- R2: For an active channel whose mode bit 1 is set, a 0-to-1 change of its request is seen after a two-flop synchroniser. It raises exactly one transfer for that channel and starts the channel's pacer.
- R3: While the synchronised request stays high, the pacer raises one further transfer every `interval` cycles. The first of these comes `interval` cycles after the edge-triggered one. An interval of 0 acts as 1.
- R4: A synchronised 1-to-0 change of the request stops that channel's pacer, and no later transfer follows. A pacer expiry in mode 2'b10 while the synchronised request is low raises no transfer.
- R5: When mode bit 1 is clear (modes 2'b00 and 2'b01), the request line is ignored: no transfer is raised and the status byte is unchanged.
- R6: `xfer_valid_o` with `xfer_ch_o` stays asserted and unchanged until `xfer_ready_i` is seen high. Each cycle with both high is exactly one transfer.
- R7: When several channels are pending in the same cycle, the lowest channel number is granted first (channel 0 highest).
- R8: A start pulse loads the count and sets status bit 3 (active). Each accepted transfer lowers the count by one. The transfer that brings it to zero sets status bits 7, 6 and 5, clears bit 3 and stops the pacer. Requests are then ignored until the next start.
- R9: Writing 1s to a channel's clear byte clears the matching status bits among 7..5, and 0 bits leave them unchanged. Bit 3 follows hardware only and cannot be cleared this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCH | Asynchronous peripheral request per channel |
| mode_i | input | 2*NCH | Mode field per channel, bits [2c+1:2c] |
| interval_i | input | IVL_W*NCH | Pacing interval in cycles per channel |
| start_i | input | NCH | One-cycle pulse that arms a channel with its count |
| count_i | input | CNT_W*NCH | Transfer count loaded on start |
| clr_i | input | 8*NCH | Write-1-to-clear pulses for status bits 7..5, per channel byte |
| xfer_ready_i | input | 1 | Transfer engine accepts the offered transfer |
| xfer_valid_o | output | 1 | A single transfer is offered |
| xfer_ch_o | output | $clog2(NCH) | Channel of the offered transfer |
| status_o | output | 8*NCH | Status byte per channel: bits 7..5 completion, bit 3 active |

## Verification
The arbiter's grant and a channel's new trigger can land in the same cycle. So can a handshake stall and a pacer expiry. The bench covers the first by raising the requests of channels 0 and 1 on the same clock. The scoreboard then requires channel 0 to appear before channel 1. It covers the second by throttling `xfer_ready_i` to one cycle in three during a paced run. The queue must still hold exactly the number of transfers the interval and hold time predict, with none lost or doubled.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_ISSUE = 1'b1
    } arb_state_e;

    localparam int ST_OPDONE  = 7;
    localparam int ST_BLKDONE = 6;
    localparam int ST_NRMEND  = 5;
    localparam int ST_ACTIVE  = 3;
endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [1:0]       mode_i,
    input  logic [IVL_W-1:0] ivl_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             grant_i,
    input  logic             ack_i,
    input  logic [7:0]       clr_i,
    output logic             pend_o,
    output logic             run_o,
    output logic             expire_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             lvl_o,
    output logic [CNT_W-1:0] left_o,
    output logic [7:0]       stat_o
);
    logic [2:0]       sync_q;
    logic [IVL_W-1:0] tmr_q;
    logic [CNT_W-1:0] left_q;
    logic [2:0]       flag_q;
    logic             run_q, pend_q, active_q;
    logic             rise, fall, expire, trig_edge, pace_fire, done;
    logic [IVL_W-1:0] ivl_eff;

    // two synchroniser stages, third stage remembers previous level
    assign rise      = sync_q[1] & ~sync_q[2];
    assign fall      = ~sync_q[1] & sync_q[2];
    assign ivl_eff   = (ivl_i == '0) ? IVL_W'(1) : ivl_i;
    assign expire    = run_q && (tmr_q <= IVL_W'(1));
    assign trig_edge = active_q & mode_i[1] & rise;
    assign pace_fire = active_q & mode_i[1] & expire & ~(~mode_i[0] & ~sync_q[1]);
    assign done      = ack_i && (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= '0;
            tmr_q    <= '0;
            left_q   <= '0;
            run_q    <= 1'b0;
            pend_q   <= 1'b0;
            active_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], req_i};
            if (start_i) begin
                left_q   <= cnt_i;
                active_q <= |cnt_i;
                pend_q   <= 1'b0;
                run_q    <= 1'b0;
                tmr_q    <= '0;
            end else begin
                if (ack_i) left_q <= left_q - CNT_W'(1);
                if (done) active_q <= 1'b0;

                if (done)                        pend_q <= 1'b0;
                else if (trig_edge || pace_fire) pend_q <= 1'b1;
                else if (grant_i)                pend_q <= 1'b0;

                if (done || fall || !active_q) begin
                    run_q <= 1'b0;
                end else if (trig_edge) begin
                    run_q <= 1'b1;
                    tmr_q <= ivl_eff;
                end else if (expire) begin
                    tmr_q <= ivl_eff;
                end else if (run_q) begin
                    tmr_q <= tmr_q - IVL_W'(1);
                end
            end
        end
    end

    // completion flags: set on the final transfer, write-1 clears; set wins
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= '0;
        else if (done) flag_q <= 3'b111;
        else           flag_q <= flag_q & ~clr_i[ST_OPDONE:ST_NRMEND];
    end

    always_comb begin
        stat_o = '0;
        stat_o[ST_OPDONE:ST_NRMEND] = flag_q;
        stat_o[ST_ACTIVE]           = active_q;
    end

    assign pend_o   = pend_q;
    assign run_o    = run_q;
    assign expire_o = expire;
    assign rise_o   = rise;
    assign fall_o   = fall;
    assign lvl_o    = sync_q[1];
    assign left_o   = left_q;
endmodule

// File: rtl/dma_seq_arb.sv
module dma_seq_arb
    import dma_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  pend_i,
    input  logic            ready_i,
    output logic            valid_o,
    output logic [CH_W-1:0] ch_o,
    output logic [NCH-1:0]  grant_o,
    output logic [NCH-1:0]  ack_o
);
    arb_state_e      state_q, state_d;
    logic [CH_W-1:0] cur_q, sel;

    // fixed priority: lowest index wins
    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_i[i]) sel = CH_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && |pend_i) cur_q <= sel;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (|pend_i) state_d = ARB_ISSUE;
            ARB_ISSUE: if (ready_i) state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        valid_o = (state_q == ARB_ISSUE);
        ch_o    = cur_q;
        grant_o = '0;
        ack_o   = '0;
        if (state_q == ARB_IDLE && |pend_i) grant_o[sel]   = 1'b1;
        if (state_q == ARB_ISSUE && ready_i) ack_o[cur_q]  = 1'b1;
    end
endmodule

// File: rtl/dma_req_sequencer.sv
module dma_req_sequencer
    import dma_seq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int IVL_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             req_i,
    input  logic [2*NCH-1:0]           mode_i,
    input  logic [IVL_W*NCH-1:0]       interval_i,
    input  logic [NCH-1:0]             start_i,
    input  logic [CNT_W*NCH-1:0]       count_i,
    input  logic [8*NCH-1:0]           clr_i,
    input  logic                       xfer_ready_i,
    output logic                       xfer_valid_o,
    output logic [$clog2(NCH)-1:0]     xfer_ch_o,
    output logic [8*NCH-1:0]           status_o
);
    localparam int CH_W = $clog2(NCH);

    logic [NCH-1:0]       pend_w, run_w, exp_w, rise_w, fall_w, lvl_w;
    logic [NCH-1:0]       grant_w, ack_w;
    logic [CNT_W*NCH-1:0] left_w;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_seq_chan #(.CNT_W(CNT_W), .IVL_W(IVL_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_i[c]),
            .mode_i   (mode_i[2*c +: 2]),
            .ivl_i    (interval_i[IVL_W*c +: IVL_W]),
            .start_i  (start_i[c]),
            .cnt_i    (count_i[CNT_W*c +: CNT_W]),
            .grant_i  (grant_w[c]),
            .ack_i    (ack_w[c]),
            .clr_i    (clr_i[8*c +: 8]),
            .pend_o   (pend_w[c]),
            .run_o    (run_w[c]),
            .expire_o (exp_w[c]),
            .rise_o   (rise_w[c]),
            .fall_o   (fall_w[c]),
            .lvl_o    (lvl_w[c]),
            .left_o   (left_w[CNT_W*c +: CNT_W]),
            .stat_o   (status_o[8*c +: 8])
        );
    end

    dma_seq_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_w),
        .ready_i (xfer_ready_i),
        .valid_o (xfer_valid_o),
        .ch_o    (xfer_ch_o),
        .grant_o (grant_w),
        .ack_o   (ack_w)
    );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     valid,
    input logic                     ready,
    input logic [$clog2(NCH)-1:0]   ch,
    input logic [2*NCH-1:0]         mode,
    input logic [NCH-1:0]           start,
    input logic [NCH-1:0]           pend,
    input logic [NCH-1:0]           run,
    input logic [NCH-1:0]           expire,
    input logic [NCH-1:0]           rise,
    input logic [NCH-1:0]           fall,
    input logic [NCH-1:0]           lvl,
    input logic [CNT_W*NCH-1:0]     left,
    input logic [8*NCH-1:0]         stat
);
    a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(ch));

    a_r7_chan0_first: assert property (@(posedge clk) disable iff (!rst_n)
        !valid && pend[0] |=> valid && ch == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        logic last_acc;
        assign last_acc = valid && ready && (int'(ch) == c) &&
                          (left[CNT_W*c +: CNT_W] == CNT_W'(1));

        a_r2_edge_arms: assert property (@(posedge clk) disable iff (!rst_n)
            rise[c] && stat[8*c+3] && mode[2*c+1] && !start[c] && !last_acc
            |=> pend[c] && run[c]);

        a_r4_fall_stops: assert property (@(posedge clk) disable iff (!rst_n)
            fall[c] |=> !run[c]);

        a_r4_low_expiry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            expire[c] && mode[2*c +: 2] == 2'b10 && !lvl[c] && !pend[c] |=> !pend[c]);

        a_r5_mode_ignores: assert property (@(posedge clk) disable iff (!rst_n)
            !pend[c] && !mode[2*c+1] |=> !pend[c]);

        a_r8_final_status: assert property (@(posedge clk) disable iff (!rst_n)
            last_acc && !start[c]
            |=> stat[8*c+5 +: 3] == 3'b111 && !stat[8*c+3] && !run[c]);
    end
endmodule

bind dma_req_sequencer dma_seq_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (xfer_valid_o),
    .ready  (xfer_ready_i),
    .ch     (xfer_ch_o),
    .mode   (mode_i),
    .start  (start_i),
    .pend   (pend_w),
    .run    (run_w),
    .expire (exp_w),
    .rise   (rise_w),
    .fall   (fall_w),
    .lvl    (lvl_w),
    .left   (left_w),
    .stat   (status_o)
);

// File: tb/sim_dma_req_sequencer.sv
module sim_dma_req_sequencer;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;
    localparam int CNT_W = 16;
    localparam int IVL_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH-1:0]       req = '0;
    logic [2*NCH-1:0]     mode = '0;
    logic [IVL_W*NCH-1:0] ivl = '0;
    logic [NCH-1:0]       start = '0;
    logic [CNT_W*NCH-1:0] cnt = '0;
    logic [8*NCH-1:0]     clr = '0;
    logic                 ready = 1'b1;
    logic                 valid;
    logic [1:0]           ch;
    logic [8*NCH-1:0]     stat;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    bit bp = 1'b0;
    bit ended = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_req_sequencer #(.NCH(NCH), .CNT_W(CNT_W), .IVL_W(IVL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .interval_i(ivl),
        .start_i(start), .count_i(cnt), .clr_i(clr), .xfer_ready_i(ready),
        .xfer_valid_o(valid), .xfer_ch_o(ch), .status_o(stat)
    );

    task automatic report(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic setup(input int c, input logic [1:0] m, input int iv, input int k);
        mode[2*c +: 2]       = m;
        ivl[IVL_W*c +: IVL_W] = IVL_W'(iv);
        cnt[CNT_W*c +: CNT_W] = CNT_W'(k);
        start[c] = 1'b1;
        step(1);
        start[c] = 1'b0;
    endtask

    task automatic expect_xfer(input int c, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(c);
    endtask

    task automatic check_stat(input int c, input int expv, input string tag);
        @(negedge clk);
        report(tag, int'(stat[8*c +: 8]), expv);
        step(1);
    endtask

    task automatic clear(input int c, input logic [7:0] v);
        clr[8*c +: 8] = v;
        step(1);
        clr = '0;
    endtask

    task automatic drained(input string tag);
        report(tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // ready generator: throttled to one cycle in three while bp is set
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            ready = bp ? (cyc % 3 == 0) : 1'b1;
            cyc++;
        end
    end

    // monitor: each accepted transfer is popped and compared (R6, R7)
    always @(negedge clk) begin
        if (rst_n && valid && ready) begin
            if (exp_q.size() == 0) begin
                report("R6 unexpected transfer on channel", int'(ch), -1);
            end else begin
                report("R7 transfer order", int'(ch), exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(4);
        @(negedge clk);
        report("R1 valid in reset", int'(valid), 0);
        report("R1 status in reset", int'(stat), 0);
        step(1);
        rst_n = 1'b1;
        @(negedge clk);
        report("R1 valid after reset", int'(valid), 0);
        report("R1 status after reset", int'(stat), 0);
        step(1);

        // R2: single edge gives one transfer, long interval
        setup(0, 2'b10, 1000, 5);
        check_stat(0, 8'h08, "R8 start sets active");
        expect_xfer(0, 1);
        req[0] = 1'b1;
        step(20);
        req[0] = 1'b0;
        step(30);
        drained("R2 one transfer per edge");

        // R3/R4: paced transfers under back-pressure: edge + 5 expiries
        bp = 1'b1;
        setup(1, 2'b10, 20, 100);
        expect_xfer(1, 6);
        req[1] = 1'b1;
        step(110);
        req[1] = 1'b0;
        step(100);
        drained("R3 paced transfer count");
        bp = 1'b0;
        check_stat(1, 8'h08, "R4 still active after fall");

        // R9: bit 3 not clearable
        clear(1, 8'hFF);
        check_stat(1, 8'h08, "R9 active bit unaffected");

        // R8: count exhaustion in mode 11
        setup(2, 2'b11, 15, 3);
        expect_xfer(2, 3);
        req[2] = 1'b1;
        step(150);
        check_stat(2, 8'hE0, "R8 completion status");
        req[2] = 1'b0;
        step(10);
        drained("R8 exactly count transfers");
        req[2] = 1'b1;
        step(30);
        req[2] = 1'b0;
        step(10);
        drained("R8 request ignored after completion");

        // R9: write-1 clear of selected bits
        clear(2, 8'h80);
        check_stat(2, 8'h60, "R9 partial clear");
        clear(2, 8'h60);
        check_stat(2, 8'h00, "R9 full clear");

        // R5: mode bit 1 clear ignores request
        setup(3, 2'b01, 5, 5);
        req[3] = 1'b1;
        step(60);
        req[3] = 1'b0;
        step(10);
        drained("R5 no transfer in mode 01");
        check_stat(3, 8'h08, "R5 status unchanged");

        // R7: simultaneous edges on channels 1 and 0
        setup(0, 2'b10, 1000, 5);
        setup(1, 2'b10, 1000, 5);
        expect_xfer(0, 1);
        expect_xfer(1, 1);
        req[1:0] = 2'b11;
        step(20);
        req[1:0] = 2'b00;
        step(20);
        drained("R7 both channels served");

        // R3: interval 0 acts as 1, paced every cycle, stops at count
        setup(3, 2'b10, 0, 4);
        expect_xfer(3, 4);
        req[3] = 1'b1;
        step(40);
        req[3] = 1'b0;
        step(10);
        drained("R3 zero interval paces");
        check_stat(3, 8'hE0, "R3 zero interval completes");

        finish_run();
    end
endmodule